// File: doc/BRIEF.md
# Byte-Interface Serial Transceiver with Command and Status Registers

This block is an asynchronous serial transmitter and receiver. A host reaches it through a byte-wide register port. Frames carry 8 data bits, least significant bit first, with no parity and a single stop bit. Every bit lasts sixteen pulses of an oversampling enable, `tick16`, which comes from a baud generator outside the block.

The host-facing register map has four addresses:

- **Address 0** holds two mode bytes. A pointer selects which one is reached: the first write after reset lands in the first byte, and every later write lands in the second byte until a pointer-reset command.
- **Address 1** is the status byte on reads and the command byte on writes. A command carries a 3-bit miscellaneous code and separate on and off bits for each direction.
- **Address 2** is the data port. A write goes to a transmit holding register; a read pops the receive queue.
- **Address 3** reads the transmit queue level.

Outgoing bytes pass from the holding register into a transmit queue of up to 24 entries and then to the shifter. For this reason "holding register empty" and "transmit queue empty" are separate status bits. Received characters enter a small receive queue. Overrun, framing and break-change conditions are kept as sticky flags until a command clears them.

Top module: `sercom_uart`

## Requirements
- R1: After reset the status byte reads 0x0C, the level reads 0, the mode byte reads 0, `txd` is high, and both directions are disabled.
- R2: Writes to address 0 go to mode byte 1 first and to mode byte 2 after that; a read returns the byte the pointer selects. Command code 1 (bits [6:4]) moves the pointer back to mode byte 1.
- R3: Command bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter, and bit 3 disables it. When the on and off bits for one direction are written together, the off bit wins.
- R4: Each transmitted frame is a low start bit, then 8 data bits LSB first, then a high stop bit, with every bit lasting 16 `tick16` pulses. When the transmitter is idle, `txd` is high.
- R5: Status bit 2 is set while the holding register is empty, and bit 3 is set while the transmit queue is empty. A byte in the holding register moves into the queue on the next cycle, provided the queue is not full.
- R6: The level at address 3 counts queued bytes from 0 to 24. A data write made while the holding register is full is ignored.
- R7: The receiver starts a frame on a falling edge of the line and confirms the start bit on the 8th tick. A start bit that has gone high by then is rejected. Each data bit is sampled 16 ticks after the previous sample, LSB first.
- R8: Status bit 0 is set while the receive queue holds a character, and bit 1 is set while the queue is full. A read of address 2 returns the oldest character and removes it.
- R9: A character that completes while the receive queue is full sets status bit 4 (overrun) and is discarded.
- R10: A stop bit sampled low sets status bit 6 (framing error). Status bit 5 (parity) always reads 0.
- R11: Status bit 7 sets when a break starts (an all-zero character with a low stop bit) and again when the line returns high. Command code 5 clears it.
- R12: Command code 2 empties the receive queue and disables the receiver. Code 3 empties the transmit path and disables the transmitter. Code 4 clears status bits 4 and 6.
- R13: While the receiver is disabled, line activity queues nothing. While the transmitter is disabled, queued bytes stay in the queue and `txd` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops receive queue at address 2) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The bound checker watches the following on every cycle:

- the transmit level stays within its bound and never moves by more than one per cycle except on a transmitter reset;
- the off bit wins over the on bit;
- the receive-full bit implies the ready bit, and the parity bit stays clear;
- a character that arrives while the queue is full raises overrun;
- the error-clear command clears its flags;
- a held byte always reaches a queue that has room.

Some behaviours can only be shown by the bench's directed scenarios. These are the bit order and timing of the serial frames, rejection of a short start glitch, the mode pointer sequence, which byte is dropped on overrun, the two edges of a break, and the effect of disabling or resetting each direction on what actually reaches the pins.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int DATA_BITS     = 8;

    typedef enum logic [1:0] {
        REG_MODE    = 2'd0,
        REG_STATCMD = 2'd1,
        REG_DATA    = 2'd2,
        REG_LEVEL   = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        MC_NOP     = 3'd0,
        MC_PTR_RST = 3'd1,
        MC_RX_RST  = 3'd2,
        MC_TX_RST  = 3'd3,
        MC_ERR_CLR = 3'd4,
        MC_BRK_CLR = 3'd5,
        MC_RSV6    = 3'd6,
        MC_RSV7    = 3'd7
    } misc_cmd_e;

    // Command byte: bits [6:4] misc code, bit3 tx off, bit2 tx on, bit1 rx off, bit0 rx on
    typedef struct packed {
        logic [2:0] misc;
        logic       tx_off;
        logic       tx_on;
        logic       rx_off;
        logic       rx_on;
    } cmd_t;

    // Status byte, MSB first
    typedef struct packed {
        logic brk_chg;
        logic frm_err;
        logic par_err;
        logic ovr_err;
        logic tx_fifo_empty;
        logic tx_hold_empty;
        logic rx_full;
        logic rx_ready;
    } status_t;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_START = 2'd1,
        LN_DATA  = 2'd2,
        LN_STOP  = 2'd3
    } line_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 frm_err;
        logic                 is_break;
    } rx_char_t;

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        return cmd_t'(b[6:0]);
    endfunction

    // Next enable state: off bit has priority over on bit
    function automatic logic next_enable(input logic cur, input logic on_b, input logic off_b);
        if (off_b)
            return 1'b0;
        else if (on_b)
            return 1'b1;
        else
            return cur;
    endfunction

endpackage

// File: rtl/sercom_fifo.sv
module sercom_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 24,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1))
            return '0;
        else
            return p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
    import sercom_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 tick,
    input  logic                 enable,
    input  logic                 fifo_empty,
    input  logic [DATA_BITS-1:0] fifo_data,
    output logic                 fifo_pop,
    output logic                 txd
);

    localparam int TCNT_W = $clog2(TICKS_PER_BIT);
    localparam int BIDX_W = $clog2(DATA_BITS);

    line_state_e          state;
    logic [TCNT_W-1:0]    tcnt;
    logic [BIDX_W-1:0]    bidx;
    logic [DATA_BITS-1:0] shreg;
    logic                 bit_end;

    assign bit_end  = tick && (tcnt == TCNT_W'(TICKS_PER_BIT - 1));
    assign fifo_pop = (state == LN_IDLE) && enable && !fifo_empty && !clear;

    always_comb begin
        unique case (state)
            LN_START: txd = 1'b0;
            LN_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state <= LN_IDLE;
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
        end else begin
            if (state != LN_IDLE && tick) begin
                tcnt <= tcnt + 1'b1;
            end
            unique case (state)
                LN_IDLE: begin
                    if (fifo_pop) begin
                        shreg <= fifo_data;
                        tcnt  <= '0;
                        bidx  <= '0;
                        state <= LN_START;
                    end
                end
                LN_START: begin
                    if (bit_end) state <= LN_DATA;
                end
                LN_DATA: begin
                    if (bit_end) begin
                        shreg <= {1'b0, shreg[DATA_BITS-1:1]};
                        bidx  <= bidx + 1'b1;
                        if (bidx == BIDX_W'(DATA_BITS - 1)) state <= LN_STOP;
                    end
                end
                LN_STOP: begin
                    if (bit_end) state <= LN_IDLE;
                end
                default: state <= LN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
    import sercom_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     tick,
    input  logic     enable,
    input  logic     rxd_s,
    output logic     char_valid,
    output rx_char_t char_out,
    output logic     brk_edge
);

    localparam int TCNT_W = $clog2(TICKS_PER_BIT);
    localparam int BIDX_W = $clog2(DATA_BITS);

    line_state_e          state;
    logic [TCNT_W-1:0]    tcnt;
    logic [BIDX_W-1:0]    bidx;
    logic [DATA_BITS-1:0] shreg;
    logic                 rxd_prev;
    logic                 brk_active;
    logic                 mid_start;
    logic                 mid_bit;

    assign mid_start = tick && (tcnt == TCNT_W'(TICKS_PER_BIT / 2 - 1));
    assign mid_bit   = tick && (tcnt == TCNT_W'(TICKS_PER_BIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state      <= LN_IDLE;
            tcnt       <= '0;
            bidx       <= '0;
            shreg      <= '0;
            rxd_prev   <= 1'b1;
            brk_active <= 1'b0;
            char_valid <= 1'b0;
            char_out   <= '0;
            brk_edge   <= 1'b0;
        end else begin
            rxd_prev   <= rxd_s;
            char_valid <= 1'b0;
            brk_edge   <= 1'b0;
            if (state != LN_IDLE && tick) begin
                tcnt <= tcnt + 1'b1;
            end
            unique case (state)
                LN_IDLE: begin
                    if (brk_active) begin
                        if (rxd_s) begin
                            brk_active <= 1'b0;
                            brk_edge   <= 1'b1;
                        end
                    end else if (enable && rxd_prev && !rxd_s) begin
                        tcnt  <= '0;
                        state <= LN_START;
                    end
                end
                LN_START: begin
                    if (mid_start) begin
                        tcnt <= '0;
                        bidx <= '0;
                        state <= rxd_s ? LN_IDLE : LN_DATA;
                    end
                end
                LN_DATA: begin
                    if (mid_bit) begin
                        shreg <= {rxd_s, shreg[DATA_BITS-1:1]};
                        bidx  <= bidx + 1'b1;
                        if (bidx == BIDX_W'(DATA_BITS - 1)) state <= LN_STOP;
                    end
                end
                LN_STOP: begin
                    if (mid_bit) begin
                        char_valid        <= 1'b1;
                        char_out.data     <= shreg;
                        char_out.frm_err  <= !rxd_s;
                        char_out.is_break <= !rxd_s && (shreg == '0);
                        if (!rxd_s && shreg == '0) begin
                            brk_active <= 1'b1;
                            brk_edge   <= 1'b1;
                        end
                        state <= LN_IDLE;
                    end
                end
                default: state <= LN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sercom_uart.sv
module sercom_uart
    import sercom_pkg::*;
#(
    parameter int TX_DEPTH = 24,
    parameter int RX_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rxd,
    output logic       txd
);

    localparam int LVL_W = $clog2(TX_DEPTH + 1);
    localparam int RXC_W = $clog2(RX_DEPTH + 1);

    reg_sel_e  sel;
    cmd_t      cmd;
    logic      cmd_wr, tx_rst, rx_rst, ptr_rst, err_clr, brk_clr;
    logic      data_wr, data_rd, mode_wr;

    logic [1:0] rxd_sync;
    logic       rxd_s;

    logic [7:0] mode1_q, mode2_q;
    logic       mode_ptr_q;
    logic       rx_en, tx_en;
    logic [7:0] hold_q;
    logic       hold_full;
    logic       ovr_q, frm_q, brk_q;

    logic             txf_push, txf_pop, txf_full, txf_empty;
    logic [7:0]       txf_dout;
    logic [LVL_W-1:0] txf_count;

    logic             rxf_full, rxf_empty;
    logic [7:0]       rxf_dout;
    logic [RXC_W-1:0] rxf_count;

    logic     rx_valid, rx_brk_edge;
    rx_char_t rx_char;
    status_t  stat;

    assign sel     = reg_sel_e'(addr);
    assign cmd     = decode_cmd(wdata);
    assign cmd_wr  = wr_en && (sel == REG_STATCMD);
    assign ptr_rst = cmd_wr && (cmd.misc == MC_PTR_RST);
    assign rx_rst  = cmd_wr && (cmd.misc == MC_RX_RST);
    assign tx_rst  = cmd_wr && (cmd.misc == MC_TX_RST);
    assign err_clr = cmd_wr && (cmd.misc == MC_ERR_CLR);
    assign brk_clr = cmd_wr && (cmd.misc == MC_BRK_CLR);
    assign mode_wr = wr_en && (sel == REG_MODE);
    assign data_wr = wr_en && (sel == REG_DATA);
    assign data_rd = rd_en && (sel == REG_DATA);

    assign rxd_s = rxd_sync[1];

    always_ff @(posedge clk) begin
        if (rst) rxd_sync <= 2'b11;
        else     rxd_sync <= {rxd_sync[0], rxd};
    end

    // Mode pointer and mode bytes
    always_ff @(posedge clk) begin
        if (rst) begin
            mode1_q    <= '0;
            mode2_q    <= '0;
            mode_ptr_q <= 1'b0;
        end else if (ptr_rst) begin
            mode_ptr_q <= 1'b0;
        end else if (mode_wr) begin
            if (!mode_ptr_q) begin
                mode1_q    <= wdata;
                mode_ptr_q <= 1'b1;
            end else begin
                mode2_q <= wdata;
            end
        end
    end

    // Direction enables
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en <= 1'b0;
            tx_en <= 1'b0;
        end else if (cmd_wr) begin
            rx_en <= rx_rst ? 1'b0 : next_enable(rx_en, cmd.rx_on, cmd.rx_off);
            tx_en <= tx_rst ? 1'b0 : next_enable(tx_en, cmd.tx_on, cmd.tx_off);
        end
    end

    // Transmit holding register
    assign txf_push = hold_full && !txf_full;

    always_ff @(posedge clk) begin
        if (rst || tx_rst) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (data_wr && !hold_full) begin
            hold_q    <= wdata;
            hold_full <= 1'b1;
        end else if (txf_push) begin
            hold_full <= 1'b0;
        end
    end

    // Sticky flags: clear first, a new event in the same cycle wins
    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
            frm_q <= 1'b0;
            brk_q <= 1'b0;
        end else begin
            if (err_clr) begin
                ovr_q <= 1'b0;
                frm_q <= 1'b0;
            end
            if (brk_clr) brk_q <= 1'b0;
            if (rx_valid && rxf_full) ovr_q <= 1'b1;
            if (rx_valid && rx_char.frm_err) frm_q <= 1'b1;
            if (rx_brk_edge) brk_q <= 1'b1;
        end
    end

    sercom_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_txf (
        .clk   (clk),
        .rst   (rst),
        .clear (tx_rst),
        .push  (txf_push),
        .din   (hold_q),
        .pop   (txf_pop),
        .dout  (txf_dout),
        .count (txf_count),
        .full  (txf_full),
        .empty (txf_empty)
    );

    sercom_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .clear      (tx_rst),
        .tick       (tick16),
        .enable     (tx_en),
        .fifo_empty (txf_empty),
        .fifo_data  (txf_dout),
        .fifo_pop   (txf_pop),
        .txd        (txd)
    );

    sercom_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .clear      (rx_rst),
        .tick       (tick16),
        .enable     (rx_en),
        .rxd_s      (rxd_s),
        .char_valid (rx_valid),
        .char_out   (rx_char),
        .brk_edge   (rx_brk_edge)
    );

    sercom_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxf (
        .clk   (clk),
        .rst   (rst),
        .clear (rx_rst),
        .push  (rx_valid),
        .din   (rx_char.data),
        .pop   (data_rd),
        .dout  (rxf_dout),
        .count (rxf_count),
        .full  (rxf_full),
        .empty (rxf_empty)
    );

    always_comb begin
        stat               = '0;
        stat.rx_ready      = !rxf_empty;
        stat.rx_full       = rxf_full;
        stat.tx_hold_empty = !hold_full;
        stat.tx_fifo_empty = txf_empty;
        stat.ovr_err       = ovr_q;
        stat.par_err       = 1'b0;
        stat.frm_err       = frm_q;
        stat.brk_chg       = brk_q;
    end

    always_comb begin
        unique case (sel)
            REG_MODE:    rdata = mode_ptr_q ? mode2_q : mode1_q;
            REG_STATCMD: rdata = stat;
            REG_DATA:    rdata = rxf_dout;
            default:     rdata = 8'(txf_count);
        endcase
    end

endmodule

// File: rtl/sercom_uart_chk.sv
module sercom_uart_chk #(
    parameter int TX_DEPTH = 24,
    parameter int LVL_W    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [7:0]       wdata,
    input logic [7:0]       stat,
    input logic [LVL_W-1:0] txf_count,
    input logic             tx_en,
    input logic             rx_en,
    input logic             rx_valid
);

    logic cmd_wr;
    assign cmd_wr = wr_en && (addr == 2'd1);

    // R6: level never exceeds the queue depth
    a_r6_level_bound: assert property (@(posedge clk) disable iff (rst)
        int'(txf_count) <= TX_DEPTH);

    // R6: level moves by at most one per cycle unless the transmitter is reset
    a_r6_level_step: assert property (@(posedge clk) disable iff (rst)
        !(cmd_wr && wdata[6:4] == 3'd3) |=>
            (int'(txf_count) <= int'($past(txf_count)) + 1) &&
            (int'(txf_count) + 1 >= int'($past(txf_count))));

    // R3: disable bit wins for the transmitter
    a_r3_tx_off_wins: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[3]) |=> !tx_en);

    // R3: disable bit wins for the receiver
    a_r3_rx_off_wins: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[1]) |=> !rx_en);

    // R8: full receive queue is also ready
    a_r8_full_ready: assert property (@(posedge clk) disable iff (rst)
        stat[1] |-> stat[0]);

    // R10: parity flag stays clear
    a_r10_no_parity: assert property (@(posedge clk) disable iff (rst)
        !stat[5]);

    // R9: completion into a full queue raises overrun
    a_r9_overrun: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && stat[1]) |=> stat[4]);

    // R12: error clear drops overrun and framing when no character lands
    a_r12_err_clear: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[6:4] == 3'd4 && !rx_valid) |=> (!stat[4] && !stat[6]));

    // R5: a held byte moves on when the queue has room
    a_r5_hold_moves: assert property (@(posedge clk) disable iff (rst)
        (!stat[2] && int'(txf_count) < TX_DEPTH) |=> stat[2]);

endmodule

bind sercom_uart sercom_uart_chk #(.TX_DEPTH(TX_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .stat      (stat),
    .txf_count (txf_count),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .rx_valid  (rx_valid)
);

// File: tb/sim_sercom_uart.sv
`timescale 1ns/1ps
module sim_sercom_uart;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       rxd = 1'b1;
    logic       txd;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sercom_uart u0 (
        .clk    (clk),
        .rst    (rst),
        .tick16 (tick16),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .rxd    (rxd),
        .txd    (txd)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_v);
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (16) @(negedge clk);
        end
        rxd = stop_v;
        repeat (16) @(negedge clk);
        if (stop_v) rxd = 1'b1;
    endtask

    // Decode one frame on txd; ok is 0 on timeout or bad start/stop
    task automatic grab_frame(output logic [7:0] b, output logic ok);
        int t;
        t = 0;
        ok = 1'b1;
        b = 8'h00;
        while (txd === 1'b1 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 3000) begin
            ok = 1'b0;
        end else begin
            repeat (8) @(negedge clk);
            if (txd !== 1'b0) ok = 1'b0;
            for (int i = 0; i < 8; i++) begin
                repeat (16) @(negedge clk);
                b[i] = txd;
            end
            repeat (16) @(negedge clk);
            if (txd !== 1'b1) ok = 1'b0;
        end
    endtask

    task automatic test_reset();
        logic [7:0] v;
        rd(2'd1, v); check8("R1 status", v, 8'h0C);
        rd(2'd3, v); check8("R1 level", v, 8'h00);
        rd(2'd0, v); check8("R1 mode", v, 8'h00);
        check8("R1 txd", {7'd0, txd}, 8'h01);
    endtask

    task automatic test_mode();
        logic [7:0] v;
        wr(2'd0, 8'h13);
        wr(2'd0, 8'h07);
        rd(2'd0, v); check8("R2 second byte", v, 8'h07);
        wr(2'd0, 8'h21);
        rd(2'd0, v); check8("R2 stays on second", v, 8'h21);
        wr(2'd1, 8'h10);
        rd(2'd0, v); check8("R2 pointer reset", v, 8'h13);
        wr(2'd0, 8'h55);
        rd(2'd0, v); check8("R2 after rewrite", v, 8'h21);
    endtask

    task automatic test_tx_basic();
        logic [7:0] v;
        logic ok;
        bit stayed;
        wr(2'd2, 8'hA5);
        wr(2'd2, 8'h3C);
        idle(3);
        rd(2'd3, v); check8("R13 level held", v, 8'h02);
        rd(2'd1, v); check8("R5 hold empty, fifo not", v, 8'h04);
        stayed = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) stayed = 0;
        end
        check8("R13 txd idle while disabled", {7'd0, stayed}, 8'h01);
        wr(2'd1, 8'h0C);
        stayed = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) stayed = 0;
        end
        check8("R3 off wins over on", {7'd0, stayed}, 8'h01);
        wr(2'd1, 8'h04);
        grab_frame(v, ok);
        check8("R4 frame ok 1", {7'd0, ok}, 8'h01);
        check8("R4 first byte", v, 8'hA5);
        grab_frame(v, ok);
        check8("R4 frame ok 2", {7'd0, ok}, 8'h01);
        check8("R4 second byte", v, 8'h3C);
        rd(2'd3, v); check8("R6 level drained", v, 8'h00);
        rd(2'd1, v); check8("R5 all empty", v, 8'h0C);
        wr(2'd1, 8'h08);
    endtask

    task automatic test_tx_fill();
        logic [7:0] v;
        logic ok;
        int bad;
        for (int i = 0; i < 26; i++) wr(2'd2, 8'(8'h40 + i));
        idle(2);
        rd(2'd3, v); check8("R6 level max", v, 8'd24);
        rd(2'd1, v); check8("R5 hold and fifo full", v, 8'h00);
        wr(2'd1, 8'h04);
        bad = 0;
        for (int i = 0; i < 25; i++) begin
            grab_frame(v, ok);
            if (!ok || v !== 8'(8'h40 + i)) bad++;
        end
        check8("R6 25 bytes in order", 8'(bad), 8'h00);
        grab_frame(v, ok);
        check8("R6 extra write ignored", {7'd0, ok}, 8'h00);
        wr(2'd1, 8'h08);
    endtask

    task automatic test_tx_reset();
        logic [7:0] v;
        bit stayed;
        wr(2'd2, 8'h11);
        wr(2'd2, 8'h22);
        wr(2'd2, 8'h33);
        idle(2);
        rd(2'd3, v); check8("R6 level three", v, 8'h03);
        wr(2'd1, 8'h30);
        rd(2'd3, v); check8("R12 tx reset level", v, 8'h00);
        rd(2'd1, v); check8("R12 tx reset status", v, 8'h0C);
        stayed = 1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) stayed = 0;
        end
        check8("R12 nothing sent after tx reset", {7'd0, stayed}, 8'h01);
    endtask

    task automatic test_rx_disabled();
        logic [7:0] v;
        send_frame(8'h66, 1'b1);
        idle(20);
        rd(2'd1, v); check8("R13 rx disabled", v, 8'h0C);
        wr(2'd1, 8'h03);
        send_frame(8'h66, 1'b1);
        idle(20);
        rd(2'd1, v); check8("R3 rx off wins", v, 8'h0C);
    endtask

    task automatic test_rx_basic();
        logic [7:0] v;
        wr(2'd1, 8'h01);
        rxd = 1'b0; idle(3); rxd = 1'b1;
        idle(40);
        rd(2'd1, v); check8("R7 glitch rejected", v, 8'h0C);
        send_frame(8'hC3, 1'b1);
        idle(20);
        rd(2'd1, v); check8("R8 ready set", v, 8'h0D);
        rd(2'd2, v); check8("R7 data LSB first", v, 8'hC3);
        rd(2'd1, v); check8("R8 ready clear after read", v, 8'h0C);
    endtask

    task automatic test_overrun();
        logic [7:0] v;
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        send_frame(8'h33, 1'b1);
        send_frame(8'h44, 1'b1);
        idle(20);
        rd(2'd1, v); check8("R8 full", v, 8'h0F);
        send_frame(8'h55, 1'b1);
        idle(20);
        rd(2'd1, v); check8("R9 overrun", v, 8'h1F);
        rd(2'd2, v); check8("R9 keep 1", v, 8'h11);
        rd(2'd2, v); check8("R9 keep 2", v, 8'h22);
        rd(2'd2, v); check8("R9 keep 3", v, 8'h33);
        rd(2'd2, v); check8("R9 keep 4", v, 8'h44);
        rd(2'd1, v); check8("R9 last dropped", v, 8'h1C);
        wr(2'd1, 8'h40);
        rd(2'd1, v); check8("R12 overrun cleared", v, 8'h0C);
    endtask

    task automatic test_framing();
        logic [7:0] v;
        send_frame(8'h5A, 1'b0);
        rxd = 1'b1;
        idle(30);
        rd(2'd1, v); check8("R10 framing set", v, 8'h4D);
        rd(2'd2, v); check8("R10 data kept", v, 8'h5A);
        wr(2'd1, 8'h40);
        rd(2'd1, v); check8("R12 framing cleared", v, 8'h0C);
    endtask

    task automatic test_break();
        logic [7:0] v;
        send_frame(8'h00, 1'b0);
        idle(20);
        rd(2'd1, v); check8("R11 break start", v, 8'hCD);
        wr(2'd1, 8'h50);
        rd(2'd1, v); check8("R11 break flag cleared", v, 8'h4D);
        idle(20);
        rxd = 1'b1;
        idle(10);
        rd(2'd1, v); check8("R11 break end", v, 8'hCD);
        wr(2'd1, 8'h50);
        wr(2'd1, 8'h40);
    endtask

    task automatic test_rx_reset();
        logic [7:0] v;
        send_frame(8'h77, 1'b1);
        send_frame(8'h78, 1'b1);
        idle(20);
        rd(2'd1, v); check8("R8 two queued", v, 8'h0D);
        wr(2'd1, 8'h20);
        rd(2'd1, v); check8("R12 rx reset empties", v, 8'h0C);
        send_frame(8'h79, 1'b1);
        idle(20);
        rd(2'd1, v); check8("R12 rx reset disables", v, 8'h0C);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        test_reset();
        test_mode();
        test_tx_basic();
        test_tx_fill();
        test_tx_reset();
        test_rx_disabled();
        test_rx_basic();
        test_overrun();
        test_framing();
        test_break();
        test_rx_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule